// File: doc/BRIEF.md
# Sign-magnitude partial-field comparator

This block compares one partial field of two sign-plus-five-byte words: a register operand and a memory operand. The same byte range, given as a packed field code, is cut from both words. Magnitudes are compared as unsigned numbers. The sign takes part only when the field starts at the sign position, and a zero magnitude counts as positive whatever its sign bit. The result is reported from the register's point of view: register below memory, equal to it, or above it.

An index-register flag marks the register operand as a short index value. In that mode its upper three bytes are taken as zero, whatever the input carries. The three-valued result is latched into a 2-bit indicator register. The register loads only in cycles where the enable strobe is high. Jump decoding and memory access belong to neighbouring logic.

Top module: `sm_field_compare`

## Requirements
- R1: After reset the indicator is 2'b00. The indicator codes are 2'b00 EQUAL, 2'b01 LESS (register below memory) and 2'b10 GREATER. The code 2'b11 never appears.
- R2: The indicator loads the comparison result on a rising clock edge where `en` is high. When `en` is low it keeps its value, whatever the other inputs do.
- R3: `fspec` carries the left position L in bits [5:3] and the right position R in bits [2:0]. Position 0 is the sign, and positions 1..5 are bytes, with byte 1 the most significant. Only bytes L..R of each word take part, and differences outside them have no effect.
- R4: When L is not 0, the sign bits are ignored and both fields count as positive.
- R5: A negative zero equals a positive zero.
- R6: When L is 0, the comparison is signed. A negative nonzero value is below any positive or zero value. Of two negative values, the one with the larger magnitude is the smaller.
- R7: The field (0:0), `fspec` = 0, always gives EQUAL.
- R8: When `idx_mode` is high, register bytes 1, 2 and 3 count as zero. For example, the field (1:2), `fspec` = 10, can then never give GREATER.
- R9: A malformed field, with L greater than R or R greater than 5, gives EQUAL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Load strobe for the indicator |
| idx_mode | input | 1 | Register operand is a two-byte index value |
| fspec | input | 6 | Field code 8L+R |
| reg_word | input | 31 | Register operand: bit 30 is the sign (1 = minus), then bytes 1..5 from the MSB down |
| mem_word | input | 31 | Memory operand, with the same layout |
| ind | output | 2 | Comparison indicator |

## Verification
On every cycle the assertions check several rules:
- the indicator never takes the unused code and holds while the strobe is low;
- identical words compare equal;
- the sign-only field and malformed fields give EQUAL;
- an index-mode (1:2) comparison is never GREATER.

The ordering rules depend on the data: signed order with negative values, minus zero against plus zero, and bytes outside the field being ignored. Only the bench can show these. It compares every cycle against a behavioural integer model, using both chosen corner words and random operands.

// File: rtl/sm_field_compare.sv
module sm_field_compare #(
  parameter int BYTE_W = 6,
  parameter int NBYTES = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         en,
  input  logic                         idx_mode,
  input  logic [5:0]                   fspec,
  input  logic [BYTE_W*NBYTES:0]       reg_word,
  input  logic [BYTE_W*NBYTES:0]       mem_word,
  output logic [1:0]                   ind
);
  localparam int MAG_W = BYTE_W * NBYTES;
  localparam logic [1:0] C_EQ = 2'b00;
  localparam logic [1:0] C_LT = 2'b01;
  localparam logic [1:0] C_GT = 2'b10;

  logic [2:0] fl_l, fl_r;
  logic [MAG_W-1:0] mag_r, mag_m;
  logic fld_ok, sgn_on, neg_r, neg_m;
  logic [1:0] res;

  assign fl_l = fspec[5:3];
  assign fl_r = fspec[2:0];
  assign fld_ok = (fl_l <= fl_r) && (fl_r <= 3'(NBYTES));
  assign sgn_on = fld_ok && (fl_l == 3'd0);

  for (genvar k = 1; k <= NBYTES; k++) begin : g_byte
    localparam logic [2:0] POS = 3'(k);
    localparam int LSB = (NBYTES - k) * BYTE_W;
    logic in_fld, reg_keep;
    assign in_fld   = fld_ok && (POS >= fl_l) && (POS <= fl_r);
    assign reg_keep = in_fld && !(idx_mode && (k <= NBYTES - 2));
    assign mag_r[LSB +: BYTE_W] = reg_keep ? reg_word[LSB +: BYTE_W] : '0;
    assign mag_m[LSB +: BYTE_W] = in_fld   ? mem_word[LSB +: BYTE_W] : '0;
  end

  assign neg_r = sgn_on && reg_word[MAG_W] && (|mag_r);
  assign neg_m = sgn_on && mem_word[MAG_W] && (|mag_m);

  always_comb begin
    if (neg_r != neg_m)        res = neg_r ? C_LT : C_GT;
    else if (mag_r == mag_m)   res = C_EQ;
    else if (mag_r > mag_m)    res = neg_r ? C_LT : C_GT;
    else                       res = neg_r ? C_GT : C_LT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  ind <= C_EQ;
    else if (en) ind <= res;
  end
endmodule

module sm_field_compare_chk #(
  parameter int BYTE_W = 6,
  parameter int NBYTES = 5
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   en,
  input logic                   idx_mode,
  input logic [5:0]             fspec,
  input logic [BYTE_W*NBYTES:0] reg_word,
  input logic [BYTE_W*NBYTES:0] mem_word,
  input logic [1:0]             ind
);
  p_code_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ind != 2'b11);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(ind));
  p_same_equal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !idx_mode && reg_word == mem_word) |=> ind == 2'b00);
  p_sign_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && fspec == 6'd0) |=> ind == 2'b00);
  p_index_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && idx_mode && fspec == 6'd10) |=> ind != 2'b10);
  p_bad_field_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (fspec[5:3] > fspec[2:0] || fspec[2:0] > 3'(NBYTES))) |=> ind == 2'b00);
endmodule

bind sm_field_compare sm_field_compare_chk #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .idx_mode(idx_mode), .fspec(fspec),
  .reg_word(reg_word), .mem_word(mem_word), .ind(ind)
);

// File: tb/sm_field_compare_test.sv
module sm_field_compare_test;
  localparam int CLK_PERIOD = 10;
  localparam int BW = 6;
  localparam int NB = 5;
  localparam int WW = BW * NB + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic idx_mode = 1'b0;
  logic [5:0] fspec = '0;
  logic [WW-1:0] reg_word = '0;
  logic [WW-1:0] mem_word = '0;
  logic [1:0] ind;

  int n_tests = 0;
  int n_fail = 0;
  logic [1:0] exp_ind = 2'b00;

  sm_field_compare #(.BYTE_W(BW), .NBYTES(NB)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .idx_mode(idx_mode), .fspec(fspec),
    .reg_word(reg_word), .mem_word(mem_word), .ind(ind)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [WW-1:0] mk(bit s, int b1, int b2, int b3, int b4, int b5);
    logic [WW-1:0] w;
    w = {s, BW'(b1), BW'(b2), BW'(b3), BW'(b4), BW'(b5)};
    return w;
  endfunction

  function automatic longint fval(logic [WW-1:0] w, int l, int r, bit idx);
    longint v = 0;
    int lo = (l < 1) ? 1 : l;
    for (int k = lo; k <= r; k++) begin
      int b = int'(w[(NB-k)*BW +: BW]);
      if (idx && k <= NB - 2) b = 0;
      v = v * (longint'(1) << BW) + b;
    end
    if (l == 0 && w[WW-1]) v = -v;
    return v;
  endfunction

  function automatic logic [1:0] model(logic [WW-1:0] rw, logic [WW-1:0] mw, logic [5:0] f, bit idx);
    int l = int'(f[5:3]);
    int r = int'(f[2:0]);
    longint a, b;
    if (l > r || r > NB) return 2'b00;
    a = fval(rw, l, r, idx);
    b = fval(mw, l, r, 1'b0);
    if (a < b) return 2'b01;
    if (a > b) return 2'b10;
    return 2'b00;
  endfunction

  task automatic check(logic [1:0] expv, string tag);
    n_tests++;
    if (ind !== expv) begin
      n_fail++;
      $display("FAIL %s: ind=%b expected=%b", tag, ind, expv);
    end
  endtask

  task automatic step(logic [WW-1:0] rw, logic [WW-1:0] mw, logic [5:0] f,
                      bit idx, bit e, string tag);
    reg_word = rw; mem_word = mw; fspec = f; idx_mode = idx; en = e;
    @(posedge clk);
    if (e) exp_ind = model(rw, mw, f, idx);
    @(negedge clk);
    check(exp_ind, tag);
  endtask

  function automatic logic [5:0] fc(int l, int r);
    return 6'(l * 8 + r);
  endfunction

  initial begin
    #(CLK_PERIOD * 20000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: ind=%b expected=finish", ind);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(2'b00, "R1 reset");
    rst_n = 1'b1;

    step(mk(0,1,2,3,5,9), mk(1,7,2,3,3,0), fc(4,4), 0, 1, "R3 byte4 only");
    check(2'b10, "R3 byte4 greater");
    step(mk(0,1,2,3,5,9), mk(1,1,2,3,9,60), fc(1,3), 0, 1, "R3 outside ignored");
    check(2'b00, "R3 outside ignored");
    step(mk(1,0,0,0,0,10), mk(0,0,0,0,0,5), fc(1,5), 0, 1, "R4 sign dropped");
    check(2'b10, "R4 sign dropped");
    step(mk(1,0,0,0,0,0), mk(0,0,0,0,0,0), fc(0,5), 0, 1, "R5 minus zero");
    check(2'b00, "R5 minus zero");
    step(mk(1,0,0,0,0,3), mk(0,0,0,0,0,2), fc(0,5), 0, 1, "R6 neg vs pos");
    check(2'b01, "R6 neg vs pos");
    step(mk(1,0,0,0,0,2), mk(1,0,0,0,0,3), fc(0,5), 0, 1, "R6 both neg");
    check(2'b10, "R6 both neg");
    step(mk(0,0,0,0,0,1), mk(1,0,0,0,0,0), fc(0,5), 0, 1, "R6 pos vs minus zero");
    check(2'b10, "R6 pos vs minus zero");
    step(mk(1,0,0,0,0,5), mk(0,0,0,0,0,0), fc(0,4), 0, 1, "R5 field zero both");
    check(2'b00, "R5 field zero both");
    step(mk(1,9,9,9,9,9), mk(0,1,1,1,1,1), fc(0,0), 0, 1, "R7 sign only");
    check(2'b00, "R7 sign only");
    step(mk(0,63,63,63,0,0), mk(0,0,0,0,0,0), fc(1,2), 1, 1, "R8 index 1:2");
    check(2'b00, "R8 index 1:2");
    step(mk(0,40,40,40,0,1), mk(0,0,0,0,0,2), fc(0,5), 1, 1, "R8 index upper zero");
    check(2'b01, "R8 index upper zero");
    step(mk(0,0,0,0,0,9), mk(0,0,0,0,0,1), fc(0,5), 0, 1, "R2 load greater");
    step(mk(1,0,0,0,0,9), mk(0,0,0,0,0,1), fc(0,5), 0, 0, "R2 hold");
    check(2'b10, "R2 hold");
    step(mk(0,0,0,0,0,9), mk(0,0,0,0,0,1), fc(3,2), 0, 1, "R9 L above R");
    check(2'b00, "R9 L above R");
    step(mk(0,0,0,0,0,9), mk(0,0,0,0,0,1), fc(2,7), 0, 1, "R9 R above 5");
    check(2'b00, "R9 R above 5");

    for (int i = 0; i < 3000; i++) begin
      logic [WW-1:0] a, b;
      int l, r;
      a = WW'($urandom);
      b = (i % 4 == 0) ? a : WW'($urandom);
      if (i % 7 == 0) b[BW-1:0] = a[BW-1:0] ^ 6'd1;
      l = $urandom_range(0, 5);
      r = $urandom_range(l, 5);
      if (i % 50 == 0) r = $urandom_range(0, 7);
      step(a, b, fc(l, r), (i % 5 == 0), (i % 9 != 0), "R6 random");
    end

    rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    exp_ind = 2'b00;
    check(2'b00, "R1 re-reset");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule